// File: doc/BRIEF.md
# Control Port Mode Detector

This block decides whether a slave control port speaks I2C or SPI. The port comes out of reset in I2C mode. A host selects SPI by pulling the shared select/address pin low three times. Each low pulse must span at least one master clock period to count. The select pin is sampled in the master clock domain through a synchronizer. On the third qualified pulse the block switches to SPI and stays there until the next reset.

In I2C mode the same shared pins act as static address straps. The block brings out two device-address bits: bit 1 comes from the select pin and bit 2 from the MOSI pin. When the mode changes, a one-cycle strobe tells the protocol engines downstream to clear their state. The protocol engines, the pads and the clock generation are outside this block.

Top module: `ctl_port_mode_detect`

## Requirements
- R1: After reset `spiMode` is 0 (I2C), `modeChanged` is 0, and no pulses are counted.
- R2: Three qualified low pulses on `selPin` set `spiMode` to 1. `spiMode` rises on the third clock edge after the pin returns high at the end of the third pulse.
- R3: A low level on `selPin` that no rising clock edge samples is not counted.
- R4: One or two qualified pulses leave `spiMode` at 0.
- R5: In I2C mode `addrBits[0]` follows `selPin`, delayed by the two-flop synchronizer (valid within three clock cycles). It is the bit 1 of the device address word.
- R6: In I2C mode `addrBits[1]` follows `mosiPin` with the same delay. It is the bit 2 of the device address word.
- R7: Once `spiMode` is 1 it stays 1 until reset, whatever `selPin` does.
- R8: `modeChanged` is high for exactly one cycle, in the same cycle in which `spiMode` first reads 1, and never at any other time.
- R9: While `spiMode` is 1, `addrBits` reads 2'b00.
- R10: A reset in the middle of the sequence discards the partial pulse count, so three new pulses are needed after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| selPin | input | 1 | Raw shared select / address-bit-1 pin |
| mosiPin | input | 1 | Raw shared MOSI / address-bit-2 pin |
| spiMode | output | 1 | 0 = I2C, 1 = SPI (latched) |
| modeChanged | output | 1 | One-cycle strobe on the switch to SPI |
| addrBits | output | 2 | {address bit 2, address bit 1} in I2C mode, 0 in SPI mode |

## Verification
The bench fires glitches shorter than a clock period between two sampling edges. A detector that watched the raw pin, or that counted edges without checking the sampled width, would move to SPI too early. The bench also stops after two pulses and resets partway through a sequence. This catches an off-by-one threshold and a count that survives reset. After the switch the bench keeps toggling the pin and counts strobe cycles. A mode that is not latched would fall back to I2C, and a strobe that is not edge-based would repeat. The address outputs are checked for both pin polarities in I2C mode and for zero in SPI mode.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  typedef enum logic {
    MODE_I2C = 1'b0,
    MODE_SPI = 1'b1
  } portMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic freeze;   // stop pulse qualification
    logic spiSel;   // gate address outputs
  } cpmCmd_t;
endpackage

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       selPin,
  input  logic       mosiPin,
  input  cpmCmd_t    cmd,
  output logic       pulseSeen,
  output logic [1:0] addrBits
);
  localparam int RUN_W = $clog2(MIN_LOW + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_LOW);

  logic [SYNC_STAGES-1:0] selChain;
  logic [SYNC_STAGES-1:0] mosiChain;
  logic selSync, mosiSync, selPrev;
  logic [RUN_W-1:0] lowRun;

  // Synchronizers; select idles high, so reset it high
  always_ff @(posedge clk) begin
    if (rst) begin
      selChain  <= '1;
      mosiChain <= '0;
    end else begin
      selChain  <= {selChain[SYNC_STAGES-2:0], selPin};
      mosiChain <= {mosiChain[SYNC_STAGES-2:0], mosiPin};
    end
  end

  assign selSync  = selChain[SYNC_STAGES-1];
  assign mosiSync = mosiChain[SYNC_STAGES-1];

  // Width of the current low level, in sampled cycles, saturating
  always_ff @(posedge clk) begin
    if (rst || cmd.freeze) begin
      lowRun  <= '0;
      selPrev <= 1'b1;
    end else begin
      selPrev <= selSync;
      if (!selSync) begin
        if (lowRun != RUN_MAX) lowRun <= lowRun + 1'b1;
      end else begin
        lowRun <= '0;
      end
    end
  end

  // A qualified pulse ends on the sampled rising edge
  assign pulseSeen = selSync && !selPrev && (lowRun == RUN_MAX) && !cmd.freeze;

  assign addrBits = cmd.spiSel ? 2'b00 : {mosiSync, selSync};
endmodule

// File: rtl/cpm_control.sv
module cpm_control
  import cpm_pkg::*;
#(
  parameter int PULSE_TARGET = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pulseSeen,
  output cpmCmd_t cmd,
  output logic    spiMode,
  output logic    modeChanged
);
  localparam int CNT_W = $clog2(PULSE_TARGET + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_TARGET - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(PULSE_TARGET);

  portMode_t modeQ;
  logic [CNT_W-1:0] pulseCnt;
  logic strobeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ    <= MODE_I2C;
      pulseCnt <= '0;
      strobeQ  <= 1'b0;
    end else begin
      strobeQ <= 1'b0;
      if (modeQ == MODE_I2C && pulseSeen) begin
        if (pulseCnt == CNT_LAST) begin
          modeQ    <= MODE_SPI;
          pulseCnt <= CNT_SAT;
          strobeQ  <= 1'b1;
        end else begin
          pulseCnt <= pulseCnt + 1'b1;
        end
      end
    end
  end

  assign cmd.freeze   = (modeQ == MODE_SPI) || (pulseCnt == CNT_SAT);
  assign cmd.spiSel   = (modeQ == MODE_SPI);
  assign spiMode      = (modeQ == MODE_SPI);
  assign modeChanged  = strobeQ;
endmodule

// File: rtl/ctl_port_mode_detect.sv
module ctl_port_mode_detect
  import cpm_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_LOW      = 1,
  parameter int PULSE_TARGET = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       selPin,
  input  logic       mosiPin,
  output logic       spiMode,
  output logic       modeChanged,
  output logic [1:0] addrBits
);
  cpmCmd_t cmd;
  logic pulseSeen;

  cpm_datapath #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)) u_dp (
    .clk(clk), .rst(rst), .selPin(selPin), .mosiPin(mosiPin),
    .cmd(cmd), .pulseSeen(pulseSeen), .addrBits(addrBits)
  );

  cpm_control #(.PULSE_TARGET(PULSE_TARGET)) u_ctl (
    .clk(clk), .rst(rst), .pulseSeen(pulseSeen),
    .cmd(cmd), .spiMode(spiMode), .modeChanged(modeChanged)
  );
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker (
  input logic       clk,
  input logic       rst,
  input logic       spiMode,
  input logic       modeChanged,
  input logic [1:0] addrBits
);
  AST_RESET_I2C: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !spiMode && !modeChanged); // R1
  AST_SPI_HELD: assert property (@(posedge clk) disable iff (rst)
    spiMode |=> spiMode); // R7
  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(spiMode) |-> modeChanged); // R8
  AST_STROBE_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    modeChanged |-> spiMode && !$past(spiMode)); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    modeChanged |=> !modeChanged); // R8
  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
    spiMode |-> addrBits == 2'b00); // R9
endmodule

bind ctl_port_mode_detect cpm_checker u_chk (
  .clk(clk), .rst(rst), .spiMode(spiMode),
  .modeChanged(modeChanged), .addrBits(addrBits)
);

// File: tb/sim_ctl_port_mode_detect.sv
`timescale 1ns/1ps
module sim_ctl_port_mode_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic selPin = 1'b1;
  logic mosiPin = 1'b0;
  logic spiMode, modeChanged;
  logic [1:0] addrBits;
  int errors = 0;
  int checks = 0;
  int strobeCycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ctl_port_mode_detect u0 (
    .clk(clk), .rst(rst), .selPin(selPin), .mosiPin(mosiPin),
    .spiMode(spiMode), .modeChanged(modeChanged), .addrBits(addrBits)
  );

  always @(negedge clk) if (!rst && modeChanged) strobeCycles++;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; selPin = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    strobeCycles = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input int lowCycles);
    @(negedge clk); selPin = 1'b0;
    repeat (lowCycles) @(negedge clk);
    selPin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic glitch();
    @(negedge clk);
    #0.5 selPin = 1'b0;
    #1.0 selPin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 mode", spiMode, 0);
    check("R1 strobe", modeChanged, 0);
  endtask

  task automatic t_addr();
    do_reset();
    mosiPin = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 sel high", addrBits[0], 1);
    check("R6 mosi high", addrBits[1], 1);
    mosiPin = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 mosi low", addrBits[1], 0);
    check("R5 sel still high", addrBits[0], 1);
  endtask

  task automatic t_glitch();
    do_reset();
    for (int i = 0; i < 5; i++) glitch();
    check("R3 glitches ignored", spiMode, 0);
    pulse(1); pulse(1);
    check("R3 glitches not counted", spiMode, 0);
    pulse(1);
    check("R3 switch after three real pulses", spiMode, 1);
  endtask

  task automatic t_two();
    do_reset();
    pulse(1);
    check("R4 one pulse", spiMode, 0);
    pulse(3);
    check("R4 two pulses", spiMode, 0);
    check("R4 strobe quiet", strobeCycles, 0);
  endtask

  task automatic t_reset_mid();
    do_reset();
    pulse(2); pulse(2);
    do_reset();
    pulse(2);
    check("R10 count cleared", spiMode, 0);
    pulse(2);
    check("R10 still I2C", spiMode, 0);
    pulse(2);
    check("R10 three new pulses", spiMode, 1);
  endtask

  task automatic t_switch();
    do_reset();
    mosiPin = 1'b1;
    pulse(1); pulse(2);
    @(negedge clk); selPin = 1'b0;
    repeat (2) @(negedge clk);
    selPin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 not yet after two edges", spiMode, 0);
    @(negedge clk);
    check("R2 mode on third edge", spiMode, 1);
    check("R8 strobe same cycle", modeChanged, 1);
    @(negedge clk);
    check("R8 strobe one cycle", modeChanged, 0);
    check("R9 address quiet", addrBits, 0);
    for (int i = 0; i < 4; i++) pulse(2);
    selPin = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 latched", spiMode, 1);
    check("R9 address quiet low pin", addrBits, 0);
    selPin = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 single strobe", strobeCycles, 1);
    mosiPin = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_addr();
    t_glitch();
    t_two();
    t_reset_mid();
    t_switch();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule